// File: doc/BRIEF.md
# Bus Event Status and Mask Register Pair

This block holds the bus event status bits of a device controller together with an interrupt mask, both reachable through a plain read/write register port. Event detectors elsewhere in the chip pulse single-cycle inputs when a resume, a bus reset, a token in the wrong direction for an endpoint, or high-speed signalling from the host is seen. Each pulse sets a sticky status bit, and software clears that bit by writing a one to it. One status bit is not stored here at all. It reads as one whenever an external error register holds any nonzero value.

Every status bit whose mask bit is zero feeds a single OR. That OR sets a sticky summary interrupt output, and software clears the output through a dedicated clear input. Masking only keeps a bit away from the summary. The status bit still sets as usual, so software can poll it. After reset every source is masked.

Top module: `bus_evt_irq_regs`

## Requirements
- R1: After reset the status register reads 0x00 (with the error input low), the mask register reads 0xFF and `irq` is 0.
- R2: Status bit 6 records resume, bit 5 bus reset, bit 4 endpoint direction error and bit 3 high-speed host. Each is set by its event pulse and cleared by writing 1 to that bit at the status address. Writing 0 leaves the bit unchanged.
- R3: Status bit 2 reads 1 exactly while `err_nonzero` is high. Writes to the status address never change it.
- R4: When an event pulse and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A mask bit of 1 does not stop the matching status bit from setting.
- R6: Status bits 7, 1 and 0 always read 0. Mask bits 7, 1 and 0 always read 1, and writing 0 to them changes nothing.
- R7: `irq` becomes 1 on the clock edge after any cycle in which a status bit in positions 6..2 is 1 while its mask bit is 0. Pulsing `irq_clr` drops `irq` on the next edge only if no such unmasked bit is 1 in that cycle. Otherwise `irq` stays 1.
- R8: The high-speed event sets bit 3 only in a cycle where `suspended` is high. Otherwise the pulse is ignored.
- R9: The status register sits at address 0xAB and the mask register at 0xAC. `rdata` shows the addressed register in the same cycle. Any other address reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ev_resume | input | 1 | Resume detected pulse |
| ev_bus_rst | input | 1 | Bus reset detected pulse |
| ev_dir_err | input | 1 | Wrong-direction token pulse |
| ev_hs_host | input | 1 | High-speed host detected pulse |
| suspended | input | 1 | Device is in suspend state |
| err_nonzero | input | 1 | External error register is nonzero |
| irq_clr | input | 1 | Clear the summary interrupt |
| irq | output | 1 | Sticky summary interrupt |

## Verification
The main sweep tries all 32 mask settings of bits 6..2. For each one it raises every source alone, which shows that each mask bit gates exactly its own source and no other. Clear writes are tried with ones and zeros, with a colliding event in the same cycle, and on the error bit and reserved bits. These patterns separate write-1-clear from plain write and show that the set path has priority. `irq_clr` is pulsed both with a source still pending and with none pending, which shows that a pending source holds the summary. The high-speed pulse is given with and without `suspended`, and writes to an unmapped address are compared against the unchanged register contents.

// File: rtl/bus_evt_irq_regs.sv
module bus_evt_irq_regs #(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'hAB,
  parameter logic [AW-1:0] MASK_ADDR = 8'hAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          ev_resume,
  input  logic          ev_bus_rst,
  input  logic          ev_dir_err,
  input  logic          ev_hs_host,
  input  logic          suspended,
  input  logic          err_nonzero,
  input  logic          irq_clr,
  output logic          irq
);

  logic [3:0] st_q;
  logic [4:0] msk_q;
  logic       irq_q;
  logic       wr_st, wr_msk;
  logic [3:0] st_set, st_clr;
  logic [4:0] st_view;
  logic       pend;

  assign wr_st   = wr_en && (addr == STAT_ADDR);
  assign wr_msk  = wr_en && (addr == MASK_ADDR);
  assign st_set  = {ev_resume, ev_bus_rst, ev_dir_err, ev_hs_host & suspended};
  assign st_clr  = wr_st ? wdata[6:3] : 4'b0;
  assign st_view = {st_q, err_nonzero};
  assign pend    = |(st_view & ~msk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      msk_q <= '1;
      irq_q <= 1'b0;
    end else begin
      st_q <= (st_q & ~st_clr) | st_set;
      if (wr_msk) msk_q <= wdata[6:2];
      irq_q <= pend | (irq_q & ~irq_clr);
    end
  end

  always_comb begin
    if (addr == STAT_ADDR)      rdata = {1'b0, st_view, 2'b00};
    else if (addr == MASK_ADDR) rdata = {1'b1, msk_q, 2'b11};
    else                        rdata = 8'h00;
  end

  assign irq = irq_q;

endmodule

// File: rtl/bus_evt_irq_regs_chk.sv
module bus_evt_irq_regs_chk #(
  parameter int          AW        = 8,
  parameter logic [AW-1:0] STAT_ADDR = 8'hAB,
  parameter logic [AW-1:0] MASK_ADDR = 8'hAC
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          ev_resume,
  input logic          err_nonzero,
  input logic          irq_clr,
  input logic          irq,
  input logic [3:0]    st_q,
  input logic [4:0]    msk_q
);

  logic pend_c;
  assign pend_c = |({st_q, err_nonzero} & ~msk_q);

  assert_err_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_ADDR) |-> (rdata[2] == err_nonzero));

  assert_rsvd_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == STAT_ADDR) |-> (rdata[7] == 1'b0 && rdata[1:0] == 2'b00));

  assert_rsvd_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == MASK_ADDR) |-> (rdata[7] == 1'b1 && rdata[1:0] == 2'b11));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resume |=> st_q[3]);

  assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == STAT_ADDR && wdata[6] && !ev_resume) |=> !st_q[3]);

  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_c |=> irq);

  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pend_c));

  assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !pend_c) |=> !irq);

endmodule

bind bus_evt_irq_regs bus_evt_irq_regs_chk #(.AW(AW), .STAT_ADDR(STAT_ADDR), .MASK_ADDR(MASK_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .ev_resume(ev_resume), .err_nonzero(err_nonzero), .irq_clr(irq_clr), .irq(irq),
  .st_q(st_q), .msk_q(msk_q)
);

// File: tb/test_bus_evt_irq_regs.sv
module test_bus_evt_irq_regs;

  localparam logic [7:0] SA = 8'hAB;
  localparam logic [7:0] MA = 8'hAC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ev_resume = 0, ev_bus_rst = 0, ev_dir_err = 0, ev_hs_host = 0;
  logic       suspended = 0, err_nonzero = 0, irq_clr = 0;
  logic       irq;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_st;
  logic [4:0] m_msk;
  logic       m_irq;

  always #5 clk = ~clk;

  bus_evt_irq_regs i_bus_evt_irq_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ev_resume(ev_resume), .ev_bus_rst(ev_bus_rst), .ev_dir_err(ev_dir_err),
    .ev_hs_host(ev_hs_host), .suspended(suspended), .err_nonzero(err_nonzero),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, release pulses
  task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                      input logic [3:0] ev, input logic clr);
    logic [3:0] set_v, clr_v;
    logic       pend;
    @(negedge clk);
    addr = a; wr_en = w; wdata = d; irq_clr = clr;
    {ev_resume, ev_bus_rst, ev_dir_err, ev_hs_host} = ev;
    pend  = |({m_st, err_nonzero} & ~m_msk);
    set_v = {ev[3], ev[2], ev[1], ev[0] & suspended};
    clr_v = (w && a == SA) ? d[6:3] : 4'b0;
    @(posedge clk);
    m_st  = (m_st & ~clr_v) | set_v;
    if (w && a == MA) m_msk = d[6:2];
    m_irq = pend | (m_irq & ~clr);
    @(negedge clk);
    wr_en = 0; irq_clr = 0;
    {ev_resume, ev_bus_rst, ev_dir_err, ev_hs_host} = 4'b0;
  endtask

  task automatic idle();
    step(8'h00, 1'b0, 8'h00, 4'b0, 1'b0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic check_state(input string req);
    logic [7:0] v;
    rd(SA, v); chk(req, v, {1'b0, m_st, err_nonzero, 2'b00});
    rd(MA, v); chk(req, v, {1'b1, m_msk, 2'b11});
    chk(req, {7'b0, irq}, {7'b0, m_irq});
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    m_st = 4'b0; m_msk = 5'h1F; m_irq = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset values
    rd(SA, v); chk("R1", v, 8'h00);
    rd(MA, v); chk("R1", v, 8'hFF);
    chk("R1", {7'b0, irq}, 8'h00);

    // R5 events set status while masked; irq stays low
    suspended = 1;
    step(8'h00, 0, 8'h00, 4'b1111, 0); idle();
    check_state("R5");
    rd(SA, v); chk("R5", v, 8'h78);

    // R2 writing zeros leaves bits, then per-bit W1C
    step(SA, 1, 8'h00, 4'b0, 0); check_state("R2");
    for (int k = 3; k <= 6; k++) begin
      step(SA, 1, 8'h01 << k, 4'b0, 0);
      check_state("R2");
    end
    rd(SA, v); chk("R2", v, 8'h00);

    // R8 high-speed event ignored without suspend
    suspended = 0;
    step(8'h00, 0, 8'h00, 4'b0001, 0); rd(SA, v); chk("R8", v, 8'h00);
    suspended = 1;
    step(8'h00, 0, 8'h00, 4'b0001, 0); rd(SA, v); chk("R8", v, 8'h08);
    step(SA, 1, 8'h08, 4'b0, 0);

    // R4 set wins over same-cycle clear, for each bit
    for (int k = 0; k < 4; k++) begin
      step(8'h00, 0, 8'h00, 4'b1 << k, 0);
      step(SA, 1, 8'hFF, 4'b1 << k, 0);
      rd(SA, v); chk("R4", v, 8'h08 << k);
      step(SA, 1, 8'hFF, 4'b0, 0);
    end

    // R3 error bit mirrors input, ignores writes
    err_nonzero = 1; #1;
    rd(SA, v); chk("R3", v, 8'h04);
    step(SA, 1, 8'hFF, 4'b0, 0); rd(SA, v); chk("R3", v, 8'h04);
    err_nonzero = 0; #1;
    rd(SA, v); chk("R3", v, 8'h00);

    // R6 reserved mask bits ignore zeros
    step(MA, 1, 8'h00, 4'b0, 0);
    rd(MA, v); chk("R6", v, 8'h83);
    step(MA, 1, 8'hFF, 4'b0, 0);
    rd(MA, v); chk("R6", v, 8'hFF);

    // R9 unmapped address: no effect, reads zero
    step(8'hAD, 1, 8'h00, 4'b0, 0);
    step(8'hAA, 1, 8'hFF, 4'b0, 0);
    rd(8'hAA, v); chk("R9", v, 8'h00);
    rd(8'hAD, v); chk("R9", v, 8'h00);
    check_state("R9");

    // R7 sweep: every mask value, every source alone
    for (int m = 0; m < 32; m++) begin
      step(MA, 1, {1'b1, m[4:0], 2'b11}, 4'b0, 0);
      step(8'h00, 0, 8'h00, 4'b0, 1);
      for (int k = 0; k < 5; k++) begin
        if (k == 0) begin
          err_nonzero = 1;
          idle(); idle();
          chk("R7", {7'b0, irq}, {7'b0, ~m[0]});
          err_nonzero = 0;
        end else begin
          step(8'h00, 0, 8'h00, 4'b1 << (k - 1), 0);
          idle();
          chk("R7", {7'b0, irq}, {7'b0, ~m[k]});
          check_state("R5");
          step(SA, 1, 8'h78, 4'b0, 0);
        end
        step(8'h00, 0, 8'h00, 4'b0, 1);
        chk("R7", {7'b0, irq}, 8'h00);
      end
    end

    // R7 clear while pending keeps irq; clear after source gone drops it
    step(MA, 1, 8'h00, 4'b0, 0);
    step(8'h00, 0, 8'h00, 4'b1000, 0); idle();
    chk("R7", {7'b0, irq}, 8'h01);
    step(8'h00, 0, 8'h00, 4'b0, 1);
    chk("R7", {7'b0, irq}, 8'h01);
    check_state("R7");
    step(SA, 1, 8'h40, 4'b0, 0);
    idle();
    chk("R7", {7'b0, irq}, 8'h01);
    step(8'h00, 0, 8'h00, 4'b0, 1);
    chk("R7", {7'b0, irq}, 8'h00);
    check_state("R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule